// File: doc/BRIEF.md
# Ethernet Descriptor Ring Manager

This block keeps the buffer descriptor tables for a 10/100 Ethernet MAC and walks them on behalf of the transmit and receive engines. A single descriptor store of `NUM_DESC` entries is divided by a programmable split point. Entries below the split form the transmit ring, and the entries from the split upward form the receive ring. Each entry holds two 32-bit words: a control/status/length word and a buffer address word. The host reads and writes both words through a simple register port.

Ownership passes between host and MAC through one flag bit per descriptor. On the transmit side the block requests a frame whenever the current descriptor is marked ready. It presents that descriptor's length, buffer address and per-frame options. When the engine reports completion, the block stores the engine's status, returns the descriptor to the host and moves to the next entry. On the receive side the block offers the current descriptor's buffer while it is marked empty. When the engine reports a stored frame, the block writes the length and status back and advances. If no buffer is free, it records a busy event and drops the frame.

Completion events go into an interrupt source register, which the host clears by writing ones. A mask register with the same layout gates these sources onto one interrupt line.

Top module: `ebd_ring_mgr`

## Requirements
- R1: Host map (byte addresses). The status word of entry n is at 0x400+8n and its buffer address at 0x404+8n. Interrupt sources are at 0x000, the mask (bits 6:0) at 0x004 and the transmit entry count at 0x008. Read data appears on `hst_rdata` the cycle after `hst_rd`. After reset all descriptor words are zero, sources and mask are zero and the transmit count is NUM_DESC/2.
- R2: A write to the transmit count stores the written value, saturated at NUM_DESC (128 by default), and returns both ring indices to entry 0 of their rings. The receive ring spans entries count to NUM_DESC-1.
- R3: In a transmit status word, bit 15 is ready, 14 is interrupt enable, 13 is wrap, 12 is pad, 11 is CRC append and 31:16 is the length. `tx_req` is high while the current transmit descriptor has ready set. While it is high, `tx_len`, `tx_addr`, `tx_pad` and `tx_crc` carry that descriptor's fields.
- R4: `tx_done` while `tx_req` is high clears bit 15 and replaces bits 8:0 with `tx_stat`, keeping all other bits. The `tx_stat` bits are: 0 carrier lost, 1 deferred, 2 late collision, 3 retry limit, 7:4 retry count, 8 underrun. `tx_done` while `tx_req` is low changes nothing.
- R5: After each completed descriptor a ring moves to entry 0 of the ring if the descriptor had wrap set or was the ring's last entry. Otherwise it moves to the next entry.
- R6: `rx_ready` is high while the current receive descriptor has bit 15 (empty) set, and `rx_addr` is its buffer address. `rx_frame` while `rx_ready` is high does three things. It writes `rx_len` to bits 31:16, clears bit 15 and puts `rx_stat` in bits 8:0, keeping bits 14:9. The `rx_stat` bits are: 0 late collision, 1 CRC error, 2 short, 3 long, 4 dribble, 5 bad symbol, 6 overrun, 7 missed, 8 control frame.
- R7: `rx_frame` while `rx_ready` is low sets source bit 4 (busy) and leaves descriptors and indices unchanged.
- R8: Source bits are set only when the completed descriptor has interrupt enable (bit 14) set. A transmit completion sets bit 1 if any of status bits 0, 2, 3 or 8 is set, and bit 0 otherwise. A receive completion sets bit 3 if any of status bits 0, 1, 2, 3, 5, 6 or 7 is set, and bit 2 otherwise.
- R9: Writing a 1 to a bit of the source register clears that bit, and a 0 leaves it unchanged. A new source bit is readable the cycle after the event edge.
- R10: `irq` is high exactly when some source bit and the same mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 11 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after strobe |
| tx_req | output | 1 | Current transmit descriptor is ready |
| tx_len | output | 16 | Frame length of current transmit descriptor |
| tx_addr | output | 32 | Buffer address of current transmit descriptor |
| tx_pad | output | 1 | Pad option of current transmit descriptor |
| tx_crc | output | 1 | CRC append option of current transmit descriptor |
| tx_done | input | 1 | Transmit engine finished the current frame |
| tx_stat | input | 9 | Transmit completion status |
| rx_ready | output | 1 | Current receive descriptor is empty |
| rx_addr | output | 32 | Buffer address of current receive descriptor |
| rx_frame | input | 1 | Receive engine stored a frame |
| rx_len | input | 16 | Received length including CRC |
| rx_stat | input | 9 | Receive completion status |
| irq | output | 1 | Masked interrupt |

## Verification
Host writes reach the descriptor store on the clock edge that samples them. The MAC-side outputs (`tx_req`, `tx_addr`, `rx_ready`, `rx_addr`) follow from that stored state with no further register stage, and so does `irq`. A register read returns its word one edge after the strobe. A completion pulse changes the write-back word, the ring index and the source bits on the same edge. The bench drives every stimulus on a falling edge and samples on the next falling edge, exactly one rising edge later. It then reads memory back through the host port to confirm write-backs and untouched entries.

// File: rtl/ebd_pkg.sv
package ebd_pkg;
  localparam int OWN_BIT  = 15;
  localparam int IE_BIT   = 14;
  localparam int WRAP_BIT = 13;
  localparam int PAD_BIT  = 12;
  localparam int CRC_BIT  = 11;
  localparam int SRC_W    = 7;

  localparam int EV_TX_OK  = 0;
  localparam int EV_TX_ERR = 1;
  localparam int EV_RX_OK  = 2;
  localparam int EV_RX_ERR = 3;
  localparam int EV_BUSY   = 4;

  localparam logic [8:0] TX_ERR_BITS = 9'h10D;
  localparam logic [8:0] RX_ERR_BITS = 9'h0EF;

  function automatic logic [31:0] tx_writeback(input logic [31:0] old, input logic [8:0] st);
    return {old[31:16], 1'b0, old[14:9], st};
  endfunction

  function automatic logic [31:0] rx_writeback(input logic [31:0] old, input logic [15:0] len,
                                               input logic [8:0] st);
    return {len, 1'b0, old[14:9], st};
  endfunction

  function automatic logic [SRC_W-1:0] tx_event(input logic [31:0] old, input logic [8:0] st);
    logic [SRC_W-1:0] v;
    v = '0;
    if (old[IE_BIT]) begin
      if ((st & TX_ERR_BITS) != 9'd0) v[EV_TX_ERR] = 1'b1;
      else                            v[EV_TX_OK]  = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [SRC_W-1:0] rx_event(input logic [31:0] old, input logic [8:0] st);
    logic [SRC_W-1:0] v;
    v = '0;
    if (old[IE_BIT]) begin
      if ((st & RX_ERR_BITS) != 9'd0) v[EV_RX_ERR] = 1'b1;
      else                            v[EV_RX_OK]  = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/ebd_table.sv
module ebd_table #(
  parameter int NUM_DESC = 128,
  localparam int DW = $clog2(2 * NUM_DESC),
  localparam int EW = $clog2(NUM_DESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [DW-1:0] host_widx,
  input  logic [31:0]   host_wdata,
  input  logic [DW-1:0] host_ridx,
  output logic [31:0]   host_rword,
  input  logic [EW-1:0] tx_ent,
  output logic [31:0]   tx_sword,
  output logic [31:0]   tx_aword,
  input  logic          tx_we,
  input  logic [31:0]   tx_wstat,
  input  logic [EW-1:0] rx_ent,
  output logic [31:0]   rx_sword,
  output logic [31:0]   rx_aword,
  input  logic          rx_we,
  input  logic [31:0]   rx_wstat
);
  localparam int WORDS = 2 * NUM_DESC;

  logic [31:0] mem [WORDS];

  // Host write first; engine write-backs override on the same word.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (host_we) mem[host_widx] <= host_wdata;
      if (tx_we)   mem[{tx_ent, 1'b0}] <= tx_wstat;
      if (rx_we)   mem[{rx_ent, 1'b0}] <= rx_wstat;
    end
  end

  assign host_rword = mem[host_ridx];
  assign tx_sword   = mem[{tx_ent, 1'b0}];
  assign tx_aword   = mem[{tx_ent, 1'b1}];
  assign rx_sword   = mem[{rx_ent, 1'b0}];
  assign rx_aword   = mem[{rx_ent, 1'b1}];
endmodule

// File: rtl/ebd_ring_ptr.sv
module ebd_ring_ptr #(
  parameter int IW = 7,
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic          wrap,
  input  logic [CW-1:0] count,
  output logic [IW-1:0] idx
);
  function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] cur, input logic w,
                                              input logic [CW-1:0] cnt);
    logic [CW-1:0] inc;
    inc = {1'b0, cur} + CW'(1);
    if (w || inc >= cnt) return '0;
    return inc[IW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (clear)   idx <= '0;
    else if (advance) idx <= ring_next(idx, wrap, count);
  end

  a_r5_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> ({1'b0, idx} < count));
endmodule

// File: rtl/ebd_irq_ctl.sv
module ebd_irq_ctl
  import ebd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set,
  input  logic             clr_we,
  input  logic [SRC_W-1:0] clr,
  input  logic             mask_we,
  input  logic [SRC_W-1:0] mask_wd,
  output logic [SRC_W-1:0] src,
  output logic [SRC_W-1:0] mask,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= '0;
      mask <= '0;
    end else begin
      src <= (src & ~(clr_we ? clr : '0)) | set;
      if (mask_we) mask <= mask_wd;
    end
  end

  assign irq = |(src & mask);

  a_r9_event_sets_source: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((src & $past(set)) == $past(set)));
  a_r9_clear_drops_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && set == '0) |=> ((src & $past(clr)) == '0));
endmodule

// File: rtl/ebd_ring_mgr.sv
module ebd_ring_mgr
  import ebd_pkg::*;
#(
  parameter int NUM_DESC = 128,
  localparam int EW = $clog2(NUM_DESC),
  localparam int CW = EW + 1,
  localparam int DW = $clog2(2 * NUM_DESC),
  localparam int HAW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hst_rd,
  input  logic           hst_wr,
  input  logic [HAW-1:0] hst_addr,
  input  logic [31:0]    hst_wdata,
  output logic [31:0]    hst_rdata,
  output logic           tx_req,
  output logic [15:0]    tx_len,
  output logic [31:0]    tx_addr,
  output logic           tx_pad,
  output logic           tx_crc,
  input  logic           tx_done,
  input  logic [8:0]     tx_stat,
  output logic           rx_ready,
  output logic [31:0]    rx_addr,
  input  logic           rx_frame,
  input  logic [15:0]    rx_len,
  input  logic [8:0]     rx_stat,
  output logic           irq
);
  localparam logic [CW-1:0] CNT_MAX = CW'(NUM_DESC);
  localparam logic [CW-1:0] CNT_RST = CW'(NUM_DESC / 2);

  // host decode
  logic          is_desc;
  logic [7:0]    reg_sel;
  logic [DW-1:0] widx;
  logic          cnt_wr, src_wr, mask_wr, desc_wr;

  assign is_desc = hst_addr[HAW-1];
  assign reg_sel = hst_addr[9:2];
  assign widx    = hst_addr[DW+1:2];
  assign desc_wr = hst_wr && is_desc;
  assign src_wr  = hst_wr && !is_desc && reg_sel == 8'd0;
  assign mask_wr = hst_wr && !is_desc && reg_sel == 8'd1;
  assign cnt_wr  = hst_wr && !is_desc && reg_sel == 8'd2;

  // ring split
  logic [CW-1:0] tx_cnt, rx_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      tx_cnt <= CNT_RST;
    else if (cnt_wr) tx_cnt <= (hst_wdata > 32'(NUM_DESC)) ? CNT_MAX : hst_wdata[CW-1:0];
  end
  assign rx_cnt = CNT_MAX - tx_cnt;

  // indices and entries
  logic [EW-1:0] tx_idx, rx_idx, rx_ent;
  logic [CW-1:0] rx_ent_full;
  assign rx_ent_full = tx_cnt + {1'b0, rx_idx};
  assign rx_ent      = rx_ent_full[EW-1:0];

  logic [31:0] tx_sw, tx_aw, rx_sw, rx_aw, host_rword;
  logic        tx_fire, rx_take, rx_drop;

  assign tx_req   = (tx_cnt != '0) && tx_sw[OWN_BIT];
  assign rx_ready = (rx_cnt != '0) && rx_sw[OWN_BIT];
  assign tx_fire  = tx_done && tx_req;
  assign rx_take  = rx_frame && rx_ready;
  assign rx_drop  = rx_frame && !rx_ready;

  assign tx_len  = tx_sw[31:16];
  assign tx_addr = tx_aw;
  assign tx_pad  = tx_sw[PAD_BIT];
  assign tx_crc  = tx_sw[CRC_BIT];
  assign rx_addr = rx_aw;

  ebd_table #(.NUM_DESC(NUM_DESC)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (desc_wr),
    .host_widx  (widx),
    .host_wdata (hst_wdata),
    .host_ridx  (widx),
    .host_rword (host_rword),
    .tx_ent     (tx_idx),
    .tx_sword   (tx_sw),
    .tx_aword   (tx_aw),
    .tx_we      (tx_fire),
    .tx_wstat   (tx_writeback(tx_sw, tx_stat)),
    .rx_ent     (rx_ent),
    .rx_sword   (rx_sw),
    .rx_aword   (rx_aw),
    .rx_we      (rx_take),
    .rx_wstat   (rx_writeback(rx_sw, rx_len, rx_stat))
  );

  ebd_ring_ptr #(.IW(EW)) u_tx_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cnt_wr),
    .advance (tx_fire),
    .wrap    (tx_sw[WRAP_BIT]),
    .count   (tx_cnt),
    .idx     (tx_idx)
  );

  ebd_ring_ptr #(.IW(EW)) u_rx_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cnt_wr),
    .advance (rx_take),
    .wrap    (rx_sw[WRAP_BIT]),
    .count   (rx_cnt),
    .idx     (rx_idx)
  );

  // events
  logic [SRC_W-1:0] ev_set, src, mask, busy_vec;
  always_comb begin
    busy_vec = '0;
    busy_vec[EV_BUSY] = rx_drop;
  end
  assign ev_set = (tx_fire ? tx_event(tx_sw, tx_stat) : '0)
                | (rx_take ? rx_event(rx_sw, rx_stat) : '0)
                | busy_vec;

  ebd_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (ev_set),
    .clr_we  (src_wr),
    .clr     (hst_wdata[SRC_W-1:0]),
    .mask_we (mask_wr),
    .mask_wd (hst_wdata[SRC_W-1:0]),
    .src     (src),
    .mask    (mask),
    .irq     (irq)
  );

  // host read
  always_ff @(posedge clk) begin
    if (!rst_n) hst_rdata <= '0;
    else if (hst_rd) begin
      if (is_desc) hst_rdata <= host_rword;
      else begin
        case (reg_sel)
          8'd0:    hst_rdata <= 32'(src);
          8'd1:    hst_rdata <= 32'(mask);
          8'd2:    hst_rdata <= 32'(tx_cnt);
          default: hst_rdata <= '0;
        endcase
      end
    end
  end

  a_r2_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_MAX);
  a_r3_req_needs_ring: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_cnt != '0));
  a_r7_drop_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> src[EV_BUSY]);
  a_r7_drop_holds_index: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !cnt_wr) |=> $stable(rx_idx));
  a_r5_tx_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !cnt_wr && tx_cnt > CW'(1) && !tx_sw[WRAP_BIT]) |=> (tx_idx != $past(tx_idx)));
endmodule

// File: tb/ebd_ring_mgr_tb.sv
module ebd_ring_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_rd, hst_wr;
  logic [10:0] hst_addr;
  logic [31:0] hst_wdata, hst_rdata;
  logic        tx_req, tx_pad, tx_crc, tx_done;
  logic [15:0] tx_len;
  logic [31:0] tx_addr;
  logic [8:0]  tx_stat;
  logic        rx_ready, rx_frame;
  logic [31:0] rx_addr;
  logic [15:0] rx_len;
  logic [8:0]  rx_stat;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ebd_ring_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .tx_req(tx_req), .tx_len(tx_len),
    .tx_addr(tx_addr), .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done),
    .tx_stat(tx_stat), .rx_ready(rx_ready), .rx_addr(rx_addr), .rx_frame(rx_frame),
    .rx_len(rx_len), .rx_stat(rx_stat), .irq(irq)
  );

  function automatic logic [10:0] sw(input int e);
    return 11'(32'h400 + 8 * e);
  endfunction
  function automatic logic [10:0] aw(input int e);
    return 11'(32'h404 + 8 * e);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hr(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = a;
    @(negedge clk);
    hst_rd = 1'b0;
    d = hst_rdata;
  endtask

  task automatic pulse_tx(input logic [8:0] st);
    @(negedge clk);
    tx_done = 1'b1; tx_stat = st;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic pulse_rx(input logic [15:0] len, input logic [8:0] st);
    @(negedge clk);
    rx_frame = 1'b1; rx_len = len; rx_stat = st;
    @(negedge clk);
    rx_frame = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 reset tx_req", 32'(tx_req), 0);
    chk("R1 reset rx_ready", 32'(rx_ready), 0);
    chk("R1 reset irq", 32'(irq), 0);
    hr(11'h008, d); chk("R1 reset tx count", d, 64);
    hr(11'h000, d); chk("R1 reset source", d, 0);
    hr(sw(5), d);   chk("R1 reset descriptor", d, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    hw(11'h008, 32'h300); hr(11'h008, d); chk("R2 saturation", d, 128);
    hw(11'h008, 2);       hr(11'h008, d); chk("R2 plain count", d, 2);
    hw(aw(9), 32'hCAFE_0009); hr(aw(9), d); chk("R1 address word", d, 32'hCAFE_0009);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    hw(aw(0), 32'h1000_0000);
    hw(sw(0), 32'h003C_D800);
    chk("R3 tx_req", 32'(tx_req), 1);
    chk("R3 tx_len", 32'(tx_len), 60);
    chk("R3 tx_addr", tx_addr, 32'h1000_0000);
    chk("R3 pad/crc", {30'd0, tx_pad, tx_crc}, 3);
    pulse_tx(9'h022);
    chk("R9 TXF visible", 32'(tx_req), 0);
    hr(sw(0), d);    chk("R4 write-back", d, 32'h003C_5822);
    hr(11'h000, d);  chk("R8 TXF", d, 32'h1);
    hw(aw(1), 32'h2000);
    hw(sw(1), 32'h0040_C000);
    chk("R5 next entry", tx_addr, 32'h2000);
    pulse_tx(9'h004);
    hr(sw(1), d);    chk("R4 error write-back", d, 32'h0040_4004);
    hr(11'h000, d);  chk("R8 TXE", d, 32'h3);
    hw(sw(0), 32'h0010_8000);
    chk("R5 count boundary", tx_addr, 32'h1000_0000);
    chk("R5 count boundary req", 32'(tx_req), 1);
    pulse_tx(9'h000);
    hr(11'h000, d);  chk("R8 no irq enable", d, 32'h3);
    pulse_tx(9'h1FF);
    hr(sw(0), d);    chk("R4 done ignored", d, 32'h0010_0000);
    hr(11'h000, d);  chk("R4 done ignored source", d, 32'h3);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    hw(11'h004, 32'h2);  chk("R10 masked on", 32'(irq), 1);
    hw(11'h004, 32'h1);  chk("R10 irq", 32'(irq), 1);
    hw(11'h000, 32'h1);  hr(11'h000, d); chk("R9 clear one", d, 32'h2);
    chk("R10 masked off", 32'(irq), 0);
    hw(11'h000, 32'h7F); hr(11'h000, d); chk("R9 clear all", d, 0);
  endtask

  task automatic t_wrap;
    hw(11'h008, 4);
    hw(aw(0), 32'h3000);
    hw(sw(0), 32'h0001_E000);
    chk("R2 index reset", tx_addr, 32'h3000);
    chk("R2 index reset req", 32'(tx_req), 1);
    pulse_tx(9'h000);
    hw(sw(0), 32'h0001_8000);
    chk("R5 wrap bit", 32'(tx_req), 1);
    chk("R5 wrap addr", tx_addr, 32'h3000);
    pulse_tx(9'h000);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    hw(11'h000, 32'h7F);
    hw(11'h008, 126);
    chk("R6 not empty", 32'(rx_ready), 0);
    pulse_rx(16'd64, 9'h000);
    hr(11'h000, d);  chk("R7 busy", d, 32'h10);
    hr(sw(126), d);  chk("R7 untouched", d, 0);
    hw(11'h000, 32'h10);
    hw(aw(126), 32'h5000); hw(aw(127), 32'h6000);
    hw(sw(126), 32'h0000_C000); hw(sw(127), 32'h0000_8000);
    chk("R7 index held", rx_addr, 32'h5000);
    chk("R6 rx_ready", 32'(rx_ready), 1);
    pulse_rx(16'd68, 9'h010);
    hr(sw(126), d);  chk("R6 write-back", d, 32'h0044_4010);
    hr(11'h000, d);  chk("R8 RXF", d, 32'h4);
    chk("R5 rx next", rx_addr, 32'h6000);
    pulse_rx(16'd100, 9'h002);
    hr(sw(127), d);  chk("R6 error write-back", d, 32'h0064_0002);
    hr(11'h000, d);  chk("R8 rx no enable", d, 32'h4);
    chk("R5 rx boundary", 32'(rx_ready), 0);
    hw(sw(126), 32'h0000_C000);
    chk("R5 rx first entry", rx_addr, 32'h5000);
    pulse_rx(16'd70, 9'h002);
    hr(11'h000, d);  chk("R8 RXE", d, 32'hC);
  endtask

  initial begin
    rst_n = 1'b0; hst_rd = 0; hst_wr = 0; hst_addr = '0; hst_wdata = '0;
    tx_done = 0; tx_stat = '0; rx_frame = 0; rx_len = '0; rx_stat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_tx();
    t_irq();
    t_wrap();
    t_rx();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule